// File: doc/BRIEF.md
# External Interrupt Pin Controller

This block turns an active-low external interrupt pin into an interrupt request for the processor. The pin arrives already synchronized to the block clock. A small control register selects between level recognition, where the request follows the low pin, and falling-edge recognition, where a detected edge is held in a latch until the processor acknowledges the interrupt or the block is reset. A second control bit connects or disconnects the pin from the request output.

The edge-select bit is protected against accidental reprogramming. In normal and emulation operating modes only the first register write after reset can change it. In special mode it can be rewritten freely. The enable bit can always be written. All control and status pins are plain level signals. There is no streamed data, so no valid/ready handshake and no back-pressure at the edge of the block.

Top module: `extirq_ctrl`

## Requirements
- R1: The read port always shows the control register. Bit 7 is the edge-select bit (1 = falling edge, 0 = low level). Bit 6 is the pin-enable bit (1 = connected). Bits 5 to 0 read as zero.
- R2: After reset the register reads 8'h40. The write lock and the edge latch are both clear.
- R3: When edge select is 0 and enable is 1, irq_req equals the inverse of pin_n in the same cycle, with no register in the path.
- R4: When edge select is 1, a falling edge sets the edge latch at the clock edge where the previous pin sample was 1 and the current one is 0. irq_req then stays high from the next cycle onward, whatever the pin does afterwards.
- R5: The latch clears at the clock edge after svc_ack is sampled high. If a new falling edge is sampled at the same clock edge, the set wins. The latch is also cleared at every clock edge at which edge select is 0.
- R6: The mode input is coded as 2'b00 normal, 2'b01 emulation, 2'b10 special, and 2'b11, which behaves as normal. In special mode every write updates edge select. In any other mode only the first write after reset updates it, and every later write leaves it unchanged.
- R7: Every write updates the enable bit, including a write whose edge-select part is blocked by the lock.
- R8: While enable is 0, irq_req is 0. Edge detection keeps running, so an edge latched while disabled raises irq_req as soon as enable is set.
- R9: svc_ack has no effect on irq_req in level mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_n | input | 1 | Synchronized active-low interrupt pin |
| mode | input | 2 | Operating mode (R6 coding) |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data |
| svc_ack | input | 1 | Interrupt serviced strobe |
| irq_req | output | 1 | Interrupt request to the processor |

## Verification
The bench builds the block with its default parameters: an 8-bit register, edge select at bit 7 and enable at bit 6. Because these match the field positions in the requirements, every bit of the read port, including the zero bits, can be compared directly. The random phase runs the block in each of the four mode codes, including the reserved one. Frequent writes in those runs hit the write lock in both its states, and random pin toggles together with acknowledges produce edges that coincide with service strobes and with changes to the enable bit.

// File: rtl/extirq_pkg.sv
package extirq_pkg;
  typedef enum logic [1:0] {
    MODE_NORMAL  = 2'b00,
    MODE_EMUL    = 2'b01,
    MODE_SPECIAL = 2'b10,
    MODE_RSVD    = 2'b11
  } op_mode_e;
endpackage

// File: rtl/extirq_cfg.sv
module extirq_cfg #(
  parameter int DATA_W   = 8,
  parameter int EDGE_BIT = 7,
  parameter int EN_BIT   = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wdata,
  input  logic              special,
  output logic              edge_sel,
  output logic              pin_en,
  output logic              locked,
  output logic [DATA_W-1:0] rdata
);
  // edge select: write-once unless special; enable: always writable
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      edge_sel <= 1'b0;
      pin_en   <= 1'b1;
      locked   <= 1'b0;
    end else if (wr_en) begin
      pin_en <= wdata[EN_BIT];
      if (special || !locked) edge_sel <= wdata[EDGE_BIT];
      if (!special) locked <= 1'b1;
    end
  end

  for (genvar i = 0; i < DATA_W; i++) begin : g_rd
    if (i == EDGE_BIT) begin : g_edge
      assign rdata[i] = edge_sel;
    end else if (i == EN_BIT) begin : g_en
      assign rdata[i] = pin_en;
    end else begin : g_zero
      assign rdata[i] = 1'b0;
    end
  end
endmodule

// File: rtl/extirq_edge.sv
module extirq_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_n,
  input  logic edge_mode,
  input  logic ack,
  output logic latch_q
);
  logic prev_q;
  logic fall;

  assign fall = prev_q & ~pin_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q  <= 1'b1;
      latch_q <= 1'b0;
    end else begin
      prev_q <= pin_n;
      if (!edge_mode)  latch_q <= 1'b0;
      else if (fall)   latch_q <= 1'b1;
      else if (ack)    latch_q <= 1'b0;
    end
  end
endmodule

// File: rtl/extirq_ctrl.sv
module extirq_ctrl #(
  parameter int DATA_W   = 8,
  parameter int EDGE_BIT = 7,
  parameter int EN_BIT   = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pin_n,
  input  logic [1:0]        mode,
  input  logic              reg_wr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              svc_ack,
  output logic              irq_req
);
  import extirq_pkg::*;

  localparam int MAX_BIT = (EDGE_BIT > EN_BIT) ? EDGE_BIT : EN_BIT;

  initial begin
    if (MAX_BIT >= DATA_W || EDGE_BIT == EN_BIT)
      $error("extirq_ctrl: bad field positions");
  end

  logic edge_sel, pin_en, lock_q, latch_q, special;

  assign special = (op_mode_e'(mode) == MODE_SPECIAL);

  extirq_cfg #(
    .DATA_W(DATA_W), .EDGE_BIT(EDGE_BIT), .EN_BIT(EN_BIT)
  ) u_cfg (
    .clk(clk), .rst_n(rst_n), .wr_en(reg_wr), .wdata(reg_wdata),
    .special(special), .edge_sel(edge_sel), .pin_en(pin_en),
    .locked(lock_q), .rdata(reg_rdata)
  );

  extirq_edge u_edge (
    .clk(clk), .rst_n(rst_n), .pin_n(pin_n), .edge_mode(edge_sel),
    .ack(svc_ack), .latch_q(latch_q)
  );

  assign irq_req = pin_en & (edge_sel ? latch_q : ~pin_n);
endmodule

// File: rtl/extirq_ctrl_sva.sv
module extirq_ctrl_sva (
  input logic       clk,
  input logic       rst_n,
  input logic       pin_n,
  input logic [1:0] mode,
  input logic       reg_wr,
  input logic [7:0] reg_wdata,
  input logic [7:0] reg_rdata,
  input logic       svc_ack,
  input logic       irq_req,
  input logic       lock_q,
  input logic       latch_q
);
  assert_reset_val_R2: assert property (@(posedge clk)
    $rose(rst_n) |-> (reg_rdata == 8'h40 && !lock_q && !latch_q));

  assert_rsvd_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rdata[5:0] == 6'd0);

  assert_level_follow_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!reg_rdata[7] && reg_rdata[6]) |-> (irq_req == !pin_n));

  assert_edge_set_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rdata[7] && $past(pin_n) && !pin_n) |=> latch_q);

  assert_edge_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rdata[7] && latch_q && !svc_ack && !reg_wr) |=> latch_q);

  assert_ack_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (svc_ack && pin_n) |=> !latch_q);

  assert_level_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_rdata[7] |=> !latch_q);

  assert_lock_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && mode != 2'b10 && lock_q) |=> $stable(reg_rdata[7]));

  assert_en_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr |=> (reg_rdata[6] == $past(reg_wdata[6])));

  assert_mask_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_rdata[6] |-> !irq_req);
endmodule

bind extirq_ctrl extirq_ctrl_sva u_sva (
  .clk(clk), .rst_n(rst_n), .pin_n(pin_n), .mode(mode), .reg_wr(reg_wr),
  .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .svc_ack(svc_ack),
  .irq_req(irq_req), .lock_q(lock_q), .latch_q(latch_q)
);

// File: tb/extirq_ctrl_tb.sv
module extirq_ctrl_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b1;
  logic       pin_n = 1'b1;
  logic [1:0] mode = 2'b00;
  logic       reg_wr = 1'b0;
  logic [7:0] reg_wdata = 8'h00;
  logic       svc_ack = 1'b0;
  logic [7:0] reg_rdata;
  logic       irq_req;

  int n_run = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  extirq_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .pin_n(pin_n), .mode(mode), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .svc_ack(svc_ack),
    .irq_req(irq_req)
  );

  // reference state built from the requirements
  logic m_edge, m_en, m_lock, m_prev, m_latch;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_edge <= 1'b0; m_en <= 1'b1; m_lock <= 1'b0;
      m_prev <= 1'b1; m_latch <= 1'b0;
    end else begin
      if (reg_wr) begin
        m_en <= reg_wdata[6];
        if (mode == 2'b10 || !m_lock) m_edge <= reg_wdata[7];
        if (mode != 2'b10) m_lock <= 1'b1;
      end
      m_prev <= pin_n;
      if (!m_edge)                m_latch <= 1'b0;
      else if (m_prev && !pin_n)  m_latch <= 1'b1;
      else if (svc_ack)           m_latch <= 1'b0;
    end
  end

  function automatic logic [7:0] exp_rd(input logic e, input logic en);
    return {e, en, 6'd0};
  endfunction

  function automatic logic exp_irq(input logic e, input logic en,
                                   input logic lat, input logic pin);
    return en & (e ? lat : ~pin);
  endfunction

  task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string tag);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic step(input logic wr, input logic [7:0] wd,
                      input logic ack, input logic pin);
    @(negedge clk);
    reg_wr = wr; reg_wdata = wd; svc_ack = ack; pin_n = pin;
    #1;
    chk(reg_rdata, exp_rd(m_edge, m_en), "R1");
    chk({7'd0, irq_req}, {7'd0, exp_irq(m_edge, m_en, m_latch, pin_n)},
        !m_en ? "R8" : (m_edge ? "R4" : "R3"));
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; reg_wr = 1'b0; svc_ack = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    #1 rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;

    // reset state and level mode
    step(0, 8'h00, 0, 1); chk(reg_rdata, 8'h40, "R2"); chk({7'd0, irq_req}, 8'h00, "R2");
    step(0, 8'h00, 0, 0); chk({7'd0, irq_req}, 8'h01, "R3");
    step(0, 8'h00, 1, 0); chk({7'd0, irq_req}, 8'h01, "R9");
    // first write in normal mode locks edge select
    step(1, 8'hC0, 0, 0);
    step(0, 8'h00, 0, 1); chk(reg_rdata, 8'hC0, "R6"); chk({7'd0, irq_req}, 8'h00, "R4");
    step(1, 8'h00, 0, 1);
    step(0, 8'h00, 0, 1); chk(reg_rdata, 8'h80, "R6"); chk(reg_rdata, 8'h80, "R7");
    // edge while disabled is remembered
    step(0, 8'h00, 0, 0);
    step(0, 8'h00, 0, 0); chk({7'd0, irq_req}, 8'h00, "R8");
    step(1, 8'h40, 0, 0);
    step(0, 8'h00, 0, 1); chk({7'd0, irq_req}, 8'h01, "R8"); chk({7'd0, irq_req}, 8'h01, "R4");
    step(0, 8'h00, 1, 1);
    step(0, 8'h00, 0, 1); chk({7'd0, irq_req}, 8'h00, "R5");
    // edge and acknowledge at the same clock edge: set wins
    step(0, 8'h00, 1, 0);
    step(0, 8'h00, 0, 0); chk({7'd0, irq_req}, 8'h01, "R5");

    // special mode: edge select rewritable, latch cleared in level mode
    do_reset(); mode = 2'b10;
    step(1, 8'hC0, 0, 1);
    step(1, 8'h40, 0, 1);
    step(0, 8'h00, 0, 1); chk(reg_rdata, 8'h40, "R6");
    step(1, 8'hC0, 0, 1);
    step(0, 8'h00, 0, 0);
    step(1, 8'h40, 0, 0);
    step(1, 8'hC0, 0, 0);
    step(0, 8'h00, 0, 0); chk({7'd0, irq_req}, 8'h00, "R5");

    // constrained random phases over every mode code
    for (int ph = 0; ph < 8; ph++) begin
      do_reset();
      mode = 2'(ph % 4);
      for (int i = 0; i < 400; i++) begin
        logic pin;
        pin = ($urandom % 3 == 0) ? ~pin_n : pin_n;
        step(($urandom % 8) == 0, 8'($urandom), ($urandom % 6) == 0, pin);
      end
    end

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule